// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block tracks the state of up to 256 interrupt vectors for one processor. Each vector has three flags: requested, in service and level-triggered. Each flag set is kept as a flat bitmap, and vector v sits at bit v. The bitmap can therefore also be read as 32-bit word v[7:5], bit v[4:0]. The upper nibble of a vector is its priority class. The block combines a task-priority threshold with the class of the highest in-service vector to form a processor priority. It raises an interrupt only for a pending vector whose class lies strictly above that priority.

A request source presents a vector with a trigger mode. In the same cycle it receives an acceptance flag. The processor answers a presented interrupt with an acknowledge strobe, which moves the vector from pending to in service. The processor finishes the handler with an end-of-interrupt strobe, which retires the highest in-service vector. When that vector was level-triggered, the block sends a one-cycle broadcast carrying the vector so that the originating source can re-arm.

The block is driven by two enables, one hardware and one software. Both must be high for requests to be accepted or for interrupts to be presented. The highest-vector search is combinational, so an acknowledge or end-of-interrupt takes effect at the next clock edge.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A request arrives while both enables are high and its vector's pending bit is clear. In that case `reqAccepted` is high in the same cycle and the vector is pending from the next cycle on.
- R2: When an interrupt is presented, `intVector` is the highest-numbered pending vector. When no vector is pending, `intPending` is low.
- R3: `procPriority` equals the stored task priority when the task priority's upper nibble is at least the upper nibble of the highest in-service vector. Otherwise it equals that vector with its low nibble cleared. An empty in-service set counts as vector 0. The stored task priority is the 8-bit value of the last `tprWrite`.
- R4: `intPending` is high only when both enables are high, a vector is pending, and (vector AND 0xF0) is strictly greater than `procPriority`.
- R5: When `ackIn` is high while an interrupt is presented, the presented vector leaves the pending set and enters the in-service set at the next edge. When `ackIn` is high while nothing is presented, it has no effect.
- R6: `eoiIn` clears the highest in-service vector. If that vector was level-triggered, its level flag is cleared and, in the following cycle, `eoiBcastValid` pulses for one cycle with `eoiBcastVector` equal to the vector. An edge-triggered vector produces no pulse.
- R7: `eoiIn` has no effect when no vector is in service.
- R8: A request for a vector that is already pending is not accepted. A level request in that case leaves the trigger mode unchanged. An edge request in that case marks the vector edge-triggered.
- R9: A request arriving while either enable is low is discarded, and `reqAccepted` stays low.
- R10: Synchronous reset clears the pending, in-service and level bitmaps and the task priority, and suppresses the broadcast output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hwEnable | input | 1 | Hardware enable |
| swEnable | input | 1 | Software enable |
| reqValid | input | 1 | Incoming request strobe |
| reqVector | input | 8 | Requested vector |
| reqLevel | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| reqAccepted | output | 1 | Request newly set a pending bit (same cycle) |
| ackIn | input | 1 | Processor acknowledge of the presented vector |
| eoiIn | input | 1 | End-of-interrupt strobe |
| tprWrite | input | 1 | Task-priority write strobe |
| tprData | input | 8 | Task-priority value |
| intPending | output | 1 | An interrupt is presented |
| intVector | output | 8 | Presented vector |
| procPriority | output | 8 | Current processor priority |
| eoiBcastValid | output | 1 | One-cycle pulse for a retired level-triggered vector |
| eoiBcastVector | output | 8 | Vector carried by the broadcast |

## Verification
The bench builds the block with its default parameters: an 8-bit vector and a 4-bit priority class, which gives 256 vectors in 16 classes. At this size a random stream can reach nested service several levels deep, classes blocked by the task threshold, and vectors in the upper half that only the widest part of the priority encoder reaches. Directed sequences cover the following cases:
- repeated level and edge requests for a vector that is already pending
- an end-of-interrupt with nothing in service
- an acknowledge with nothing presented
- a reset taken while every bitmap holds state

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  // Strobes from control to datapath, one per state update kind.
  typedef struct packed {
    logic setReq;     // set pending bit of reqVector
    logic writeTrig;  // write trigger mode of reqVector
    logic ackFire;    // move presented vector to service
    logic eoiFire;    // retire highest in-service vector
    logic tprLoad;    // load task priority
  } irqStrobes_t;

endpackage

// File: rtl/irq_prio_find.sv
// Combinational search for the highest set bit of a bitmap.
module irq_prio_find #(
  parameter int IDX_W = 8
) (
  input  logic [(1<<IDX_W)-1:0] bits,
  output logic                  found,
  output logic [IDX_W-1:0]      idx
);
  localparam int NUM = 1 << IDX_W;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < NUM; i++) begin
      if (bits[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_prio_pkg::*;
#(
  parameter int VEC_W   = 8,
  parameter int CLASS_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  irqStrobes_t        strobes,
  input  logic [VEC_W-1:0]   reqVector,
  input  logic               reqLevel,
  input  logic [VEC_W-1:0]   tprData,
  output logic               reqBitSet,
  output logic               topIrrValid,
  output logic [VEC_W-1:0]   topIrrVec,
  output logic [VEC_W-1:0]   procPriority,
  output logic               topIsrValid,
  output logic               eoiBcastValid,
  output logic [VEC_W-1:0]   eoiBcastVector
);
  localparam int NUM   = 1 << VEC_W;
  localparam int SUB_W = VEC_W - CLASS_W;

  logic [NUM-1:0]   irrBits, isrBits, tmrBits;
  logic [VEC_W-1:0] tprReg;
  logic [VEC_W-1:0] topIsrVec;
  logic [VEC_W-1:0] isrEff;
  logic             bcValid;
  logic [VEC_W-1:0] bcVec;

  irq_prio_find #(.IDX_W(VEC_W)) u_findIrr (
    .bits(irrBits), .found(topIrrValid), .idx(topIrrVec)
  );

  irq_prio_find #(.IDX_W(VEC_W)) u_findIsr (
    .bits(isrBits), .found(topIsrValid), .idx(topIsrVec)
  );

  assign reqBitSet = irrBits[reqVector];

  // Processor priority from task threshold and highest in-service class.
  always_comb begin
    isrEff = topIsrValid ? topIsrVec : '0;
    if (tprReg[VEC_W-1 -: CLASS_W] >= isrEff[VEC_W-1 -: CLASS_W])
      procPriority = tprReg;
    else
      procPriority = {isrEff[VEC_W-1 -: CLASS_W], {SUB_W{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irrBits <= '0;
      isrBits <= '0;
      tmrBits <= '0;
      tprReg  <= '0;
      bcValid <= 1'b0;
      bcVec   <= '0;
    end else begin
      // Set and ack never target the same vector: set needs a clear bit,
      // ack needs a set one.
      if (strobes.setReq)  irrBits[reqVector] <= 1'b1;
      if (strobes.ackFire) irrBits[topIrrVec] <= 1'b0;

      if (strobes.ackFire) isrBits[topIrrVec] <= 1'b1;
      if (strobes.eoiFire) isrBits[topIsrVec] <= 1'b0;

      // EOI clear first, request write after it so the request wins.
      if (strobes.eoiFire && tmrBits[topIsrVec]) tmrBits[topIsrVec] <= 1'b0;
      if (strobes.writeTrig) tmrBits[reqVector] <= reqLevel;

      bcValid <= strobes.eoiFire && tmrBits[topIsrVec];
      bcVec   <= (strobes.eoiFire && tmrBits[topIsrVec]) ? topIsrVec : '0;

      if (strobes.tprLoad) tprReg <= tprData;
    end
  end

  assign eoiBcastValid  = bcValid;
  assign eoiBcastVector = bcVec;
endmodule

// File: rtl/irq_control.sv
module irq_control
  import irq_prio_pkg::*;
#(
  parameter int VEC_W   = 8,
  parameter int CLASS_W = 4
) (
  input  logic               hwEnable,
  input  logic               swEnable,
  input  logic               reqValid,
  input  logic               reqLevel,
  input  logic               ackIn,
  input  logic               eoiIn,
  input  logic               tprWrite,
  input  logic               reqBitSet,
  input  logic               topIrrValid,
  input  logic [CLASS_W-1:0] topIrrClass,
  input  logic [VEC_W-1:0]   procPriority,
  input  logic               topIsrValid,
  output irqStrobes_t        strobes,
  output logic               intPending,
  output logic               reqAccepted
);
  localparam int SUB_W = VEC_W - CLASS_W;

  logic             enabled;
  logic             reqLive;
  logic [VEC_W-1:0] classFloor;

  assign enabled    = hwEnable && swEnable;
  assign reqLive    = reqValid && enabled;
  assign classFloor = {topIrrClass, {SUB_W{1'b0}}};
  assign intPending = enabled && topIrrValid && (classFloor > procPriority);
  assign reqAccepted = reqLive && !reqBitSet;

  always_comb begin
    strobes.setReq    = reqLive && !reqBitSet;
    strobes.writeTrig = reqLive && !(reqBitSet && reqLevel);
    strobes.ackFire   = ackIn && intPending;
    strobes.eoiFire   = eoiIn && topIsrValid;
    strobes.tprLoad   = tprWrite;
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int VEC_W   = 8,
  parameter int CLASS_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hwEnable,
  input  logic             swEnable,
  input  logic             reqValid,
  input  logic [VEC_W-1:0] reqVector,
  input  logic             reqLevel,
  output logic             reqAccepted,
  input  logic             ackIn,
  input  logic             eoiIn,
  input  logic             tprWrite,
  input  logic [VEC_W-1:0] tprData,
  output logic             intPending,
  output logic [VEC_W-1:0] intVector,
  output logic [VEC_W-1:0] procPriority,
  output logic             eoiBcastValid,
  output logic [VEC_W-1:0] eoiBcastVector
);
  irqStrobes_t      strobes;
  logic             reqBitSet;
  logic             topIrrValid;
  logic [VEC_W-1:0] topIrrVec;
  logic             topIsrValid;

  irq_control #(.VEC_W(VEC_W), .CLASS_W(CLASS_W)) u_ctrl (
    .hwEnable(hwEnable), .swEnable(swEnable), .reqValid(reqValid),
    .reqLevel(reqLevel), .ackIn(ackIn), .eoiIn(eoiIn), .tprWrite(tprWrite),
    .reqBitSet(reqBitSet), .topIrrValid(topIrrValid),
    .topIrrClass(topIrrVec[VEC_W-1 -: CLASS_W]),
    .procPriority(procPriority), .topIsrValid(topIsrValid),
    .strobes(strobes), .intPending(intPending), .reqAccepted(reqAccepted)
  );

  irq_datapath #(.VEC_W(VEC_W), .CLASS_W(CLASS_W)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .reqVector(reqVector),
    .reqLevel(reqLevel), .tprData(tprData), .reqBitSet(reqBitSet),
    .topIrrValid(topIrrValid), .topIrrVec(topIrrVec),
    .procPriority(procPriority), .topIsrValid(topIsrValid),
    .eoiBcastValid(eoiBcastValid), .eoiBcastVector(eoiBcastVector)
  );

  assign intVector = topIrrVec;
endmodule

// File: rtl/irq_prio_checks.sv
module irq_prio_checks #(
  parameter int VEC_W   = 8,
  parameter int CLASS_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             hwEnable,
  input logic             swEnable,
  input logic             reqValid,
  input logic             reqAccepted,
  input logic             ackIn,
  input logic             eoiIn,
  input logic             intPending,
  input logic [VEC_W-1:0] intVector,
  input logic [VEC_W-1:0] procPriority,
  input logic             eoiBcastValid
);
  p_pending_class_r4: assert property (@(posedge clk) disable iff (rst)
    intPending |-> (intVector[VEC_W-1 -: CLASS_W] > procPriority[VEC_W-1 -: CLASS_W]));

  p_enable_gate_r4: assert property (@(posedge clk) disable iff (rst)
    !(hwEnable && swEnable) |-> !intPending);

  p_accept_needs_req_r1: assert property (@(posedge clk) disable iff (rst)
    reqAccepted |-> reqValid);

  p_drop_disabled_r9: assert property (@(posedge clk) disable iff (rst)
    (reqValid && !(hwEnable && swEnable)) |-> !reqAccepted);

  p_bcast_after_eoi_r6: assert property (@(posedge clk) disable iff (rst)
    eoiBcastValid |-> $past(eoiIn));

  p_ack_retires_vector_r5: assert property (@(posedge clk) disable iff (rst)
    (ackIn && intPending) |=> !(intPending && intVector == $past(intVector)));
endmodule

bind irq_prio_ctrl irq_prio_checks #(.VEC_W(VEC_W), .CLASS_W(CLASS_W)) u_checks (
  .clk(clk), .rst(rst), .hwEnable(hwEnable), .swEnable(swEnable),
  .reqValid(reqValid), .reqAccepted(reqAccepted), .ackIn(ackIn),
  .eoiIn(eoiIn), .intPending(intPending), .intVector(intVector),
  .procPriority(procPriority), .eoiBcastValid(eoiBcastValid)
);

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 256;

  logic       clk = 1'b0;
  logic       rst;
  logic       hwEnable, swEnable, reqValid, reqLevel, ackIn, eoiIn, tprWrite;
  logic [7:0] reqVector, tprData;
  logic       reqAccepted, intPending, eoiBcastValid;
  logic [7:0] intVector, procPriority, eoiBcastVector;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_ctrl dut (
    .clk(clk), .rst(rst), .hwEnable(hwEnable), .swEnable(swEnable),
    .reqValid(reqValid), .reqVector(reqVector), .reqLevel(reqLevel),
    .reqAccepted(reqAccepted), .ackIn(ackIn), .eoiIn(eoiIn),
    .tprWrite(tprWrite), .tprData(tprData), .intPending(intPending),
    .intVector(intVector), .procPriority(procPriority),
    .eoiBcastValid(eoiBcastValid), .eoiBcastVector(eoiBcastVector)
  );

  int nCmp = 0;
  int nBad = 0;
  logic [NV-1:0] mIrr, mIsr, mTmr;
  logic [7:0]    mTpr, mBcVec;
  logic          mBcV;

  function automatic int topOf(input logic [NV-1:0] b);
    for (int i = NV-1; i >= 0; i--) if (b[i]) return i;
    return -1;
  endfunction

  function automatic logic [7:0] modelPpr();
    int t = topOf(mIsr);
    logic [7:0] isrv = (t < 0) ? 8'd0 : 8'(t);
    if (mTpr[7:4] >= isrv[7:4]) return mTpr;
    return {isrv[7:4], 4'h0};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: drive at negedge, compare, advance model, wait next negedge.
  task automatic step(input logic rv, input logic [7:0] rvec, input logic rlvl,
                      input logic ak, input logic eo, input logic tw, input logic [7:0] td);
    logic en, pend, acc;
    int tIrr, tIsr;
    logic [7:0] ppr;
    logic [NV-1:0] nIrr, nIsr, nTmr;
    logic nBcV;
    logic [7:0] nBcVec;
    reqValid = rv; reqVector = rvec; reqLevel = rlvl;
    ackIn = ak; eoiIn = eo; tprWrite = tw; tprData = td;
    #1;
    en   = hwEnable && swEnable;
    tIrr = topOf(mIrr);
    ppr  = modelPpr();
    pend = en && (tIrr >= 0) && ((tIrr & 8'hF0) > int'(ppr));
    check("R4 intPending", intPending, pend);
    if (pend) check("R2 intVector", intVector, tIrr);
    if (!pend && tIrr < 0) check("R2 no vector pending", intPending, 0);
    check("R3 procPriority", procPriority, ppr);
    acc = rv && en && !mIrr[rvec];
    if (rv && !en)          check("R9 reqAccepted disabled", reqAccepted, 0);
    else if (rv && mIrr[rvec]) check("R8 reqAccepted repeat", reqAccepted, 0);
    else                    check("R1 reqAccepted", reqAccepted, acc);
    check("R6 eoiBcastValid", eoiBcastValid, mBcV);
    if (mBcV) check("R6 eoiBcastVector", eoiBcastVector, mBcVec);
    // model update
    nIrr = mIrr; nIsr = mIsr; nTmr = mTmr; nBcV = 1'b0; nBcVec = 8'd0;
    if (ak && pend) begin nIsr[tIrr] = 1'b1; nIrr[tIrr] = 1'b0; end   // R5
    tIsr = topOf(mIsr);
    if (eo && tIsr >= 0) begin                                        // R6, R7
      nIsr[tIsr] = 1'b0;
      if (mTmr[tIsr]) begin nTmr[tIsr] = 1'b0; nBcV = 1'b1; nBcVec = 8'(tIsr); end
    end
    if (rv && en) begin
      if (!mIrr[rvec]) begin nIrr[rvec] = 1'b1; nTmr[rvec] = rlvl; end
      else if (!rlvl) nTmr[rvec] = 1'b0;                              // R8
    end
    if (tw) mTpr = td;
    mIrr = nIrr; mIsr = nIsr; mTmr = nTmr; mBcV = nBcV; mBcVec = nBcVec;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic doReset();
    rst = 1'b1;
    reqValid = 0; reqVector = 0; reqLevel = 0; ackIn = 0; eoiIn = 0;
    tprWrite = 0; tprData = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    mIrr = '0; mIsr = '0; mTmr = '0; mTpr = 0; mBcV = 0; mBcVec = 0;
    #1;
    // R10: cleared state seen at the ports
    check("R10 intPending after reset", intPending, 0);
    check("R10 procPriority after reset", procPriority, 0);
    check("R10 eoiBcastValid after reset", eoiBcastValid, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nBad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    hwEnable = 1; swEnable = 1;
    @(negedge clk);
    doReset();
    idle(2);

    // R1, R2: edge request presented; R5 ack; R6 edge EOI without pulse
    step(1, 8'h45, 0, 0, 0, 0, 0);
    step(1, 8'h33, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0, 0);     // ack 0x45
    idle(1);                        // 0x33 blocked by class 4 in service
    step(0, 0, 0, 0, 1, 0, 0);     // EOI 0x45, edge
    idle(2);
    step(0, 0, 0, 1, 0, 0, 0);     // ack 0x33
    step(0, 0, 0, 0, 1, 0, 0);
    idle(1);

    // R5: ack with nothing presented is ignored
    step(0, 0, 0, 1, 0, 0, 0);
    idle(1);

    // R8: level request repeated is dropped; R6 level EOI pulses
    step(1, 8'h80, 1, 0, 0, 0, 0);
    step(1, 8'h80, 1, 0, 0, 0, 0);
    step(1, 8'h80, 0, 0, 0, 0, 0); // R8 repeat edge makes it edge
    step(1, 8'h81, 1, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0, 0);     // ack 0x81
    step(0, 0, 0, 0, 1, 0, 0);     // EOI 0x81 level -> pulse
    idle(2);
    step(0, 0, 0, 1, 0, 0, 0);     // ack 0x80 (now edge)
    step(0, 0, 0, 0, 1, 0, 0);     // no pulse
    idle(2);

    // R7: EOI with empty service set
    step(0, 0, 0, 0, 1, 0, 0);
    idle(1);

    // R3, R4: task threshold blocks equal class
    step(0, 0, 0, 0, 0, 1, 8'h35);
    step(1, 8'h30, 0, 0, 0, 0, 0);
    step(1, 8'h3F, 1, 0, 0, 0, 0);
    idle(2);
    step(1, 8'h41, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0, 0);     // ack 0x41, PPR class 4
    step(1, 8'h92, 1, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0, 0);     // nested ack 0x92
    idle(1);
    step(0, 0, 0, 0, 1, 0, 0);     // retires 0x92 only
    idle(1);
    step(0, 0, 0, 0, 0, 1, 8'h00); // lower threshold
    idle(2);
    step(0, 0, 0, 0, 1, 0, 0);     // retire 0x41
    idle(2);

    // R9: requests while disabled
    hwEnable = 0;
    step(1, 8'hA0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0, 0);
    hwEnable = 1; swEnable = 0;
    step(1, 8'hB0, 1, 0, 0, 0, 0);
    swEnable = 1;
    idle(2);

    // Random stream
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 64 == 0) hwEnable = ~hwEnable;
      if ($urandom % 64 == 0) swEnable = ~swEnable;
      if ($urandom % 16 == 0) begin hwEnable = 1; swEnable = 1; end
      step(($urandom % 3) == 0, 8'(16 + ($urandom % 240)), 1'($urandom),
           ($urandom % 4) == 0, ($urandom % 5) == 0,
           ($urandom % 12) == 0, 8'($urandom));
    end

    // R10: reset while state is populated
    hwEnable = 1; swEnable = 1;
    step(1, 8'hE0, 1, 0, 0, 1, 8'h10);
    step(0, 0, 0, 1, 0, 0, 0);
    doReset();
    idle(3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule